// File: doc/BRIEF.md
# Late-Settle Event Monitor

This block watches one single-bit device output and decides, trial by trial, whether that output had settled when it was first sampled. An early strobe captures the output at the instant that defines the allowed resolve time. A late strobe captures it again long after any disturbance must have died away. A third strobe stores the exclusive-OR of the two captures in a status flag. A 1 in that flag means the early sample disagreed with the settled value, which is a late-settle failure.

The cycle after the status strobe is a clearing phase. In that cycle both capture registers and the status flag return to 0, so every trial starts from a known state. Two saturating counters keep running totals: one counts trials, the other counts failures. A user can clear the totals between runs and so collect a failure ratio for each resolve-time setting.

All strobes are single-cycle enables in the monitor's clock domain. No data stream enters or leaves the block, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `flag_settle_monitor`

## Requirements
- R1: On a clock edge where `smp_early` is 1 outside the clearing phase, `early_q` takes the value of `watch_in`. At all other edges except the clearing phase, `early_q` holds.
- R2: On a clock edge where `smp_late` is 1 outside the clearing phase, `late_q` takes the value of `watch_in`. At all other edges except the clearing phase, `late_q` holds.
- R3: On a clock edge where `status_stb` is 1 outside the clearing phase, `fail_flag` becomes `early_q` XOR `late_q`. A value of 1 marks a failure.
- R4: The clock cycle after an accepted `status_stb` is the clearing phase. At the end of that cycle, `early_q`, `late_q` and `fail_flag` are all 0.
- R5: Any strobe asserted during the clearing phase is ignored. It changes neither the capture registers nor either counter.
- R6: `fail_total` increases by one on the same edge where `fail_flag` goes from 0 to 1, and only then. It therefore counts at most once per trial.
- R7: `trial_total` increases by one on every accepted `status_stb`, whatever the comparison result.
- R8: Both counters are CNT_W bits wide (32 by default). Each stops at all-ones and stays there.
- R9: `clr_totals` set to 1 zeroes both counters at the next edge. It takes priority over an increment in the same cycle and leaves the capture registers and the status flag unchanged.
- R10: `rst_n` low asynchronously forces every output to 0 and ends any clearing phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_totals | input | 1 | Synchronous clear of both counters |
| watch_in | input | 1 | Observed device output |
| smp_early | input | 1 | Early capture strobe (sets the resolve time) |
| smp_late | input | 1 | Late capture strobe (settled value) |
| status_stb | input | 1 | Stores the comparison in the status flag |
| early_q | output | 1 | Early capture |
| late_q | output | 1 | Late capture |
| fail_flag | output | 1 | Latched mismatch of the two captures |
| fail_total | output | CNT_W | Saturating failure count |
| trial_total | output | CNT_W | Saturating trial count |

## Verification
The situation hardest to bring about from the ports is a strobe that lands in the one-cycle clearing phase. The bench reaches it by asserting early and status strobes, with `watch_in` high, in exactly the cycle after a status strobe. It then checks that the captures stay at 0 and that the trial count does not move. Saturation is also hard to reach at 32 bits, so the bench builds the monitor with 4-bit counters and runs enough failing trials to reach and pass all-ones. The bench also asserts a clear in the same cycle as a status strobe, to show that the clear wins.

// File: rtl/fsm_mon_pkg.sv
package fsm_mon_pkg;
  typedef struct packed {
    logic early;
    logic late;
  } capture_t;
endpackage

// File: rtl/capture_pair.sv
module capture_pair (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wipe,
  input  logic                   take_early,
  input  logic                   take_late,
  input  logic                   din,
  output fsm_mon_pkg::capture_t  cap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap <= '0;
    end else if (wipe) begin
      cap <= '0;
    end else begin
      if (take_early) cap.early <= din;
      if (take_late)  cap.late  <= din;
    end
  end
endmodule

// File: rtl/status_stage.sv
module status_stage (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stb,
  input  fsm_mon_pkg::capture_t cap,
  output logic                  flag,
  output logic                  wipe,
  output logic                  accept,
  output logic                  set_rise
);
  logic mismatch;

  assign wipe     = 1'b0 | phase_q;
  assign accept   = stb & ~phase_q;
  assign mismatch = cap.early ^ cap.late;
  assign set_rise = accept & mismatch & ~flag;

  logic phase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      flag    <= 1'b0;
    end else begin
      phase_q <= accept;
      if (phase_q)     flag <= 1'b0;
      else if (accept) flag <= mismatch;
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/flag_settle_monitor.sv
module flag_settle_monitor #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_totals,
  input  logic             watch_in,
  input  logic             smp_early,
  input  logic             smp_late,
  input  logic             status_stb,
  output logic             early_q,
  output logic             late_q,
  output logic             fail_flag,
  output logic [CNT_W-1:0] fail_total,
  output logic [CNT_W-1:0] trial_total
);
  localparam int NCNT = 2;

  fsm_mon_pkg::capture_t cap;
  logic wipe, accept, set_rise;
  logic [NCNT-1:0] inc_vec;
  logic [NCNT-1:0][CNT_W-1:0] cnt_vec;

  capture_pair u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .wipe       (wipe),
    .take_early (smp_early & ~wipe),
    .take_late  (smp_late & ~wipe),
    .din        (watch_in),
    .cap        (cap)
  );

  status_stage u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (status_stb),
    .cap      (cap),
    .flag     (fail_flag),
    .wipe     (wipe),
    .accept   (accept),
    .set_rise (set_rise)
  );

  assign inc_vec = {accept, set_rise};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_totals),
      .inc   (inc_vec[g]),
      .cnt   (cnt_vec[g])
    );
  end

  assign early_q     = cap.early;
  assign late_q      = cap.late;
  assign fail_total  = cnt_vec[0];
  assign trial_total = cnt_vec[1];
endmodule

// File: rtl/flag_settle_monitor_chk.sv
module flag_settle_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_totals,
  input logic             smp_early,
  input logic             smp_late,
  input logic             wipe,
  input logic             early_q,
  input logic             late_q,
  input logic             fail_flag,
  input logic [CNT_W-1:0] fail_total,
  input logic [CNT_W-1:0] trial_total
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assert_early_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_early && !wipe) |=> $stable(early_q));

  assert_late_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_late && !wipe) |=> $stable(late_q));

  assert_clear_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (!early_q && !late_q && !fail_flag));

  assert_phase_no_trial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wipe && !clr_totals) |=> $stable(trial_total));

  assert_fail_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_totals && $past(fail_total) != TOP && fail_total != $past(fail_total))
      |-> $rose(fail_flag));

  assert_trial_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_totals) |=> (trial_total == $past(trial_total)
                       || trial_total == $past(trial_total) + 1'b1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_total == TOP && !clr_totals) |=> fail_total == TOP);

  assert_clear_totals_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_totals |=> (fail_total == '0 && trial_total == '0));
endmodule

bind flag_settle_monitor flag_settle_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_totals  (clr_totals),
  .smp_early   (smp_early),
  .smp_late    (smp_late),
  .wipe        (wipe),
  .early_q     (early_q),
  .late_q      (late_q),
  .fail_flag   (fail_flag),
  .fail_total  (fail_total),
  .trial_total (trial_total)
);

// File: tb/tb_flag_settle_monitor.sv
module tb_flag_settle_monitor;
  localparam int W = 4;
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_totals = 1'b0, watch_in = 1'b0;
  logic smp_early = 1'b0, smp_late = 1'b0, status_stb = 1'b0;
  logic early_q, late_q, fail_flag;
  logic [W-1:0] fail_total, trial_total;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] exp_fail = '0, exp_trial = '0;

  always #4 clk = ~clk;

  flag_settle_monitor #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_totals(clr_totals), .watch_in(watch_in),
    .smp_early(smp_early), .smp_late(smp_late), .status_stb(status_stb),
    .early_q(early_q), .late_q(late_q), .fail_flag(fail_flag),
    .fail_total(fail_total), .trial_total(trial_total));

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return (v == TOP) ? v : v + 1'b1;
  endfunction

  task automatic run_trial(input logic e, input logic l, input logic clr_at_latch);
    @(negedge clk); watch_in = e; smp_early = 1'b1;
    @(negedge clk); smp_early = 1'b0; watch_in = l; smp_late = 1'b1;
    check("R1 early capture", {{(W-1){1'b0}}, early_q}, {{(W-1){1'b0}}, e});
    @(negedge clk); smp_late = 1'b0; status_stb = 1'b1; clr_totals = clr_at_latch;
    check("R2 late capture", {{(W-1){1'b0}}, late_q}, {{(W-1){1'b0}}, l});
    @(negedge clk); status_stb = 1'b0; clr_totals = 1'b0;
    if (clr_at_latch) begin
      exp_fail = '0; exp_trial = '0;
    end else begin
      exp_trial = bump(exp_trial);
      if (e ^ l) exp_fail = bump(exp_fail);
    end
    check("R3 flag", {{(W-1){1'b0}}, fail_flag}, {{(W-1){1'b0}}, e ^ l});
    check("R6/R9 fail_total", fail_total, exp_fail);
    check("R7/R9 trial_total", trial_total, exp_trial);
    @(negedge clk);
    check("R4 cleared", {{(W-3){1'b0}}, early_q, late_q, fail_flag}, '0);
  endtask

  task automatic t_reset();
    check("R10 reset flag", {{(W-3){1'b0}}, early_q, late_q, fail_flag}, '0);
    check("R10 reset totals", fail_total | trial_total, '0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_patterns();
    run_trial(1'b0, 1'b0, 1'b0);
    run_trial(1'b1, 1'b1, 1'b0);
    run_trial(1'b1, 1'b0, 1'b0);
    run_trial(1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_hold();
    @(negedge clk); watch_in = 1'b1; smp_early = 1'b1;
    @(negedge clk); smp_early = 1'b0; watch_in = 1'b0;
    @(negedge clk); watch_in = 1'b1;
    @(negedge clk);
    check("R1 hold early", {{(W-1){1'b0}}, early_q}, 1);
    check("R2 hold late", {{(W-1){1'b0}}, late_q}, 0);
    watch_in = 1'b0; smp_late = 1'b1;
    @(negedge clk); smp_late = 1'b0; status_stb = 1'b1;
    @(negedge clk); status_stb = 1'b0;
    exp_trial = bump(exp_trial); exp_fail = bump(exp_fail);
    @(negedge clk);
  endtask

  task automatic t_phase_ignore();
    @(negedge clk); watch_in = 1'b1; smp_early = 1'b1;
    @(negedge clk); smp_early = 1'b0; smp_late = 1'b1;
    @(negedge clk); smp_late = 1'b0; status_stb = 1'b1;
    @(negedge clk); exp_trial = bump(exp_trial);
    // status_stb stays high into the clearing phase; the early strobe joins it there
    smp_early = 1'b1; smp_late = 1'b1;
    @(negedge clk); smp_early = 1'b0; smp_late = 1'b0; status_stb = 1'b0; watch_in = 1'b0;
    check("R5 capture ignored", {{(W-2){1'b0}}, early_q, late_q}, '0);
    check("R5 trial ignored", trial_total, exp_trial);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 18; i++) run_trial(1'b1, 1'b0, 1'b0);
    check("R8 fail saturated", fail_total, TOP);
    check("R8 trial saturated", trial_total, TOP);
  endtask

  task automatic t_clear();
    run_trial(1'b0, 1'b1, 1'b1);
    @(negedge clk); clr_totals = 1'b1;
    @(negedge clk); clr_totals = 1'b0;
    check("R9 clear totals", fail_total | trial_total, '0);
  endtask

  task automatic t_async_reset();
    @(negedge clk); watch_in = 1'b1; smp_early = 1'b1;
    run_trial(1'b1, 1'b0, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    check("R10 async flag", {{(W-3){1'b0}}, early_q, late_q, fail_flag}, '0);
    check("R10 async totals", fail_total | trial_total, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_patterns();
    t_hold();
    t_phase_ignore();
    t_saturate();
    t_clear();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule